// File: doc/BRIEF.md
# Dual-Bank Two-Wire Configuration Register Slave

This block is a two-wire serial (I2C-style) slave that holds configuration for a clock core. It answers two adjacent 7-bit device addresses. Each address leads to its own bank of 8-bit registers, and both banks use the same 8-bit register pointer. One bank stands for non-volatile storage. Reset does not clear it. The other bank is the working set that the clock core actually uses. Software changes it on the fly.

When reset is released, the block copies the non-volatile bank into the working bank one register per cycle. It ignores the bus until that copy is finished. Register access follows the usual two-wire conventions:
- A write sends the device address, then the register pointer, then any number of data bytes.
- A read returns bytes starting at the current pointer. A combined write-pointer and repeated-start sequence sets the pointer for a read.
- The pointer advances after each byte and wraps around at the end of the bank.

A write-protect input guards only the non-volatile bank. One masked field of the working bank reassigns the shared pin from write-protect to clock output, and wp_i is then ignored. Downstream logic reads the working bank through a plain lookup port with one cycle of latency. That port has no handshake: the slave always accepts a lookup and never holds the requester off, so it needs no back-pressure. The SCL and SDA lines are oversampled by the system clock. The line inputs pass through a synchronizer, and SDA is driven open-drain through an output-enable.

Top module: `dcfg_slave`

## Requirements
- R1: A transfer addressed to 7-bit address 0x68 is acknowledged and reaches the non-volatile bank. The slave pulls SDA low only to acknowledge or to send a 0 data bit, and it changes that drive only while SCL is low.
- R2: A transfer addressed to 7-bit address 0x69 is acknowledged and reaches the working bank. A write there takes effect at once.
- R3: An address byte with any other 7-bit address is not acknowledged. SDA then stays released until the next start or stop, and no register of either bank changes.
- R4: A write has three parts: an address byte with R/W bit 0, then a pointer byte, then data bytes. Every byte is acknowledged, except as R7 says. Each data byte is stored at the pointer, and the pointer then increments, wrapping from 0xFF to 0x00.
- R5: An address byte with R/W bit 1 returns the register at the current pointer, MSB first. The pointer then increments. Further bytes follow while the master acknowledges, and sending stops at the master's NACK.
- R6: After reset, loading is high for 2^AW cycles while the working bank is filled from the non-volatile bank. The slave acknowledges nothing during that time. The non-volatile bank keeps its contents across reset.
- R7: While wp_i is high and the pin is in its write-protect function, data bytes sent to the non-volatile bank are NACKed and not stored. Address and pointer bytes are still acknowledged. The working bank stays writable.
- R8: pin_is_clk is high exactly when working register 0x1F ANDed with mask 0x01 is non-zero. While pin_is_clk is high, wp_i has no effect.
- R9: cfg_rdata shows the working register addressed by cfg_raddr as sampled at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus lines |
| rst_n | input | 1 | Active-low reset; starts the bank copy |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe | output | 1 | When high, pull SDA low |
| wp_i | input | 1 | Write-protect level from the shared pin |
| cfg_raddr | input | AW | Working-bank lookup address |
| cfg_rdata | output | 8 | Working-bank lookup data, one cycle later |
| loading | output | 1 | High while the working bank is being filled |
| pin_is_clk | output | 1 | Shared pin reassigned to clock output |

## Verification
The bench uses the default parameters: AW = 8, addresses 0x68/0x69, mode register 0x1F with mask 0x01. That makes the full 256-entry banks and the real pointer wrap from 0xFF to 0x00 reachable. It fills the whole non-volatile bank over the bus, resets, and compares every lookup-port entry against the arithmetic pattern. This covers the copy, retention across reset and the lookup latency in one sweep. It also offers all 126 foreign 7-bit addresses and expects a NACK from each. The short bit period keeps these full sweeps inside the cycle budget.

// File: rtl/dcfg_pkg.sv
package dcfg_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_REG,
    ST_RACK,
    ST_WDAT,
    ST_WACK,
    ST_TX,
    ST_MACK,
    ST_SKIP
  } dcfg_state_e;
endpackage

// File: rtl/dcfg_line_sync.sv
module dcfg_line_sync #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_c,
  output logic stop_c
);
  logic [SYNC:0] scl_p;
  logic [SYNC:0] sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= '1;
      sda_p <= '1;
    end else begin
      scl_p <= {scl_p[SYNC-1:0], scl_i};
      sda_p <= {sda_p[SYNC-1:0], sda_i};
    end
  end

  assign scl_s    = scl_p[SYNC-1];
  assign sda_s    = sda_p[SYNC-1];
  assign scl_rise = scl_p[SYNC-1] & ~scl_p[SYNC];
  assign scl_fall = ~scl_p[SYNC-1] & scl_p[SYNC];
  // SDA edges while SCL stays high mark start and stop
  assign start_c  = scl_p[SYNC-1] & scl_p[SYNC] & ~sda_p[SYNC-1] & sda_p[SYNC];
  assign stop_c   = scl_p[SYNC-1] & scl_p[SYNC] & sda_p[SYNC-1] & ~sda_p[SYNC];
endmodule

// File: rtl/dcfg_bank.sv
module dcfg_bank #(
  parameter int AW  = 8,
  parameter int NRD = 2
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [AW-1:0]            wa,
  input  logic [7:0]               wd,
  input  logic [NRD-1:0][AW-1:0]   ra,
  output logic [NRD-1:0][7:0]      rd
);
  localparam int DEPTH = 1 << AW;

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rd[g] = mem[ra[g]];
  end
endmodule

// File: rtl/dcfg_loader.sv
module dcfg_loader #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic          busy,
  output logic [AW-1:0] idx
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b1;
      idx  <= '0;
    end else if (busy) begin
      idx <= idx + 1'b1;
      if (idx == {AW{1'b1}}) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/dcfg_slave.sv
module dcfg_slave
  import dcfg_pkg::*;
#(
  parameter int         AW       = 8,
  parameter logic [6:0] NV_ADDR  = 7'h68,
  parameter logic [6:0] VOL_ADDR = 7'h69,
  parameter int         PIN_REG  = 31,
  parameter logic [7:0] PIN_MASK = 8'h01
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe,
  input  logic          wp_i,
  input  logic [AW-1:0] cfg_raddr,
  output logic [7:0]    cfg_rdata,
  output logic          loading,
  output logic          pin_is_clk
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_c, stop_c;
  logic [AW-1:0] cpy_idx;

  dcfg_state_e st;
  logic [2:0]    cnt;
  logic          full, sel_nv, rw, ack_r, mack;
  logic [7:0]    sh, tx;
  logic [AW-1:0] ptr;

  logic [1:0][AW-1:0] nv_ra;
  logic [1:0][7:0]    nv_rd;
  logic [2:0][AW-1:0] vol_ra;
  logic [2:0][7:0]    vol_rd;
  logic               nv_we, vol_bus_we, vol_we, wr_go, wp_eff, blk, addr_hit;
  logic [AW-1:0]      vol_wa;
  logic [7:0]         vol_wd, bus_rd;

  dcfg_line_sync #(.SYNC(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_c(start_c), .stop_c(stop_c)
  );

  dcfg_loader #(.AW(AW)) u_load (
    .clk(clk), .rst_n(rst_n), .busy(loading), .idx(cpy_idx)
  );

  // port 0: bus reads, port 1: copy source
  assign nv_ra[0] = ptr;
  assign nv_ra[1] = cpy_idx;
  dcfg_bank #(.AW(AW), .NRD(2)) u_nv (
    .clk(clk), .we(nv_we), .wa(ptr), .wd(sh), .ra(nv_ra), .rd(nv_rd)
  );

  // port 0: bus reads, port 1: lookup port, port 2: pin mode field
  assign vol_ra[0] = ptr;
  assign vol_ra[1] = cfg_raddr;
  assign vol_ra[2] = AW'(PIN_REG);
  assign vol_we    = loading | vol_bus_we;
  assign vol_wa    = loading ? cpy_idx : ptr;
  assign vol_wd    = loading ? nv_rd[1] : sh;
  dcfg_bank #(.AW(AW), .NRD(3)) u_vol (
    .clk(clk), .we(vol_we), .wa(vol_wa), .wd(vol_wd), .ra(vol_ra), .rd(vol_rd)
  );

  assign pin_is_clk = |(vol_rd[2] & PIN_MASK);
  assign wp_eff     = wp_i & ~pin_is_clk;
  assign blk        = sel_nv & wp_eff;
  assign bus_rd     = sel_nv ? nv_rd[0] : vol_rd[0];
  assign addr_hit   = !loading && (sh[7:1] == NV_ADDR || sh[7:1] == VOL_ADDR);
  assign wr_go      = scl_fall && (st == ST_WDAT) && full;
  assign nv_we      = wr_go && sel_nv && !blk;
  assign vol_bus_we = wr_go && !sel_nv;

  assign sda_oe = (st == ST_AACK) || (st == ST_RACK) || (st == ST_WACK && ack_r) ||
                  (st == ST_TX && !tx[7]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_rdata <= '0;
    else        cfg_rdata <= vol_rd[1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; cnt <= '0; full <= 1'b0; sh <= '0; tx <= '1; ptr <= '0;
      sel_nv <= 1'b0; rw <= 1'b0; ack_r <= 1'b0; mack <= 1'b0;
    end else if (start_c) begin
      st <= ST_ADDR; cnt <= '0; full <= 1'b0;
    end else if (stop_c) begin
      st <= ST_IDLE;
    end else begin
      if (scl_rise && (st == ST_ADDR || st == ST_REG || st == ST_WDAT)) begin
        sh  <= {sh[6:0], sda_s};
        cnt <= cnt + 1'b1;
        if (cnt == 3'd7) full <= 1'b1;
      end
      if (scl_rise && st == ST_MACK) mack <= !sda_s;
      if (scl_fall) begin
        case (st)
          ST_ADDR: if (full) begin
            full <= 1'b0;
            if (addr_hit) begin
              sel_nv <= (sh[7:1] == NV_ADDR);
              rw     <= sh[0];
              st     <= ST_AACK;
            end else st <= ST_SKIP;
          end
          ST_AACK: if (rw) begin
            st <= ST_TX; tx <= bus_rd; cnt <= '0;
          end else st <= ST_REG;
          ST_REG: if (full) begin
            full <= 1'b0; ptr <= sh[AW-1:0]; st <= ST_RACK;
          end
          ST_RACK: st <= ST_WDAT;
          ST_WDAT: if (full) begin
            full  <= 1'b0;
            st    <= ST_WACK;
            ack_r <= !blk;
            if (!blk) ptr <= ptr + 1'b1;
          end
          ST_WACK: st <= ack_r ? ST_WDAT : ST_SKIP;
          ST_TX: if (cnt == 3'd7) begin
            cnt <= '0; ptr <= ptr + 1'b1; st <= ST_MACK;
          end else begin
            tx <= {tx[6:0], 1'b1}; cnt <= cnt + 1'b1;
          end
          ST_MACK: if (mack) begin
            tx <= bus_rd; st <= ST_TX;
          end else st <= ST_SKIP;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/dcfg_slave_chk.sv
module dcfg_slave_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          loading,
  input logic          sda_oe,
  input logic          scl_s,
  input logic          wp_i,
  input logic          pin_is_clk,
  input logic          nv_we,
  input logic          vol_bus_we,
  input logic [AW-1:0] ptr
);
  // R6: no acknowledge and no bus write while the copy runs
  a_r6_no_ack_in_load: assert property (@(posedge clk) disable iff (!rst_n)
    loading |-> !sda_oe);
  a_r6_load_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !loading |=> !loading);
  a_r6_no_bus_write_in_load: assert property (@(posedge clk) disable iff (!rst_n)
    (nv_we || vol_bus_we) |-> !loading);
  // R7: protected non-volatile bank is never written
  a_r7_nv_write_needs_unprotect: assert property (@(posedge clk) disable iff (!rst_n)
    nv_we |-> !(wp_i && !pin_is_clk));
  // R4: every stored byte advances the pointer by one, with wrap
  a_r4_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (nv_we || vol_bus_we) |=> ptr == AW'($past(ptr) + 1'b1));
  // R1: SDA drive starts only while SCL is low
  a_r1_sda_drive_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);
endmodule

bind dcfg_slave dcfg_slave_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .loading(loading), .sda_oe(sda_oe), .scl_s(scl_s),
  .wp_i(wp_i), .pin_is_clk(pin_is_clk), .nv_we(nv_we), .vol_bus_we(vol_bus_we),
  .ptr(ptr)
);

// File: tb/dcfg_slave_bench.sv
module dcfg_slave_bench;
  localparam int CLK_PERIOD = 10;
  localparam int QTR        = 3;
  localparam int AW         = 8;
  localparam logic [7:0] NV_W  = 8'hD0;  // 0x68, write
  localparam logic [7:0] NV_R  = 8'hD1;
  localparam logic [7:0] VOL_W = 8'hD2;  // 0x69, write
  localparam logic [7:0] VOL_R = 8'hD3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1, wp = 1'b0;
  logic [AW-1:0] raddr = '0;
  logic sda_oe, loading, pin_is_clk, sda_line;
  logic [7:0] rdata;

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit done = 1'b0;
  logic [7:0] nv_m [256];
  logic [7:0] vol_m [256];

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  dcfg_slave u_dcfg_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .wp_i(wp), .cfg_raddr(raddr), .cfg_rdata(rdata), .loading(loading),
    .pin_is_clk(pin_is_clk)
  );

  always @(negedge clk) begin
    cyc++;
    if (cyc >= 190000 && !done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic qwait();
    repeat (QTR) @(negedge clk);
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; qwait(); scl_m = 1'b1; qwait(); sda_m = 1'b0; qwait(); scl_m = 1'b0; qwait();
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; qwait(); scl_m = 1'b1; qwait(); sda_m = 1'b1; qwait();
  endtask

  // nack = 1 means the slave did not acknowledge
  task automatic wbyte(input logic [7:0] b, output logic nack);
    for (int k = 7; k >= 0; k--) begin
      sda_m = b[k]; qwait(); scl_m = 1'b1; qwait(); qwait(); scl_m = 1'b0; qwait();
    end
    sda_m = 1'b1; qwait(); scl_m = 1'b1; qwait(); nack = sda_line; qwait(); scl_m = 1'b0; qwait();
  endtask

  task automatic rbyte(input logic give_ack, output logic [7:0] b);
    sda_m = 1'b1;
    b = '0;
    for (int k = 0; k < 8; k++) begin
      qwait(); scl_m = 1'b1; qwait(); b = {b[6:0], sda_line}; qwait(); scl_m = 1'b0;
    end
    qwait();
    sda_m = ~give_ack; qwait(); scl_m = 1'b1; qwait(); qwait(); scl_m = 1'b0; qwait();
    sda_m = 1'b1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; repeat (4) @(negedge clk); rst_n = 1'b1;
    while (loading) @(negedge clk);
    for (int i = 0; i < 256; i++) vol_m[i] = nv_m[i];
  endtask

  // write n bytes of pat starting at p; returns number of NACKed data bytes
  task automatic bus_write(input logic [7:0] dev, input logic [7:0] p, input int n,
                           input logic [7:0] seed, input string req, output int nacks);
    logic a;
    nacks = 0;
    i2c_start();
    wbyte(dev, a); chk(req, "address ack", a, 1'b0);
    wbyte(p, a);   chk(req, "pointer ack", a, 1'b0);
    for (int i = 0; i < n; i++) begin
      wbyte(8'(seed + i * 13), a);
      if (a) nacks++;
    end
    i2c_stop();
  endtask

  task automatic bus_read_check(input logic [7:0] devw, input logic [7:0] p, input int n,
                                input bit from_nv, input string req);
    logic a;
    logic [7:0] b;
    i2c_start();
    wbyte(devw, a); chk(req, "address ack", a, 1'b0);
    wbyte(p, a);    chk(req, "pointer ack", a, 1'b0);
    i2c_start();
    wbyte(devw | 8'h01, a); chk(req, "read address ack", a, 1'b0);
    for (int i = 0; i < n; i++) begin
      rbyte(i != n - 1, b);
      chk(req, "read data", b, from_nv ? nv_m[8'(p + i)] : vol_m[8'(p + i)]);
    end
    i2c_stop();
  endtask

  initial begin
    int nk;
    logic a;
    logic [7:0] b;
    repeat (5) @(negedge clk);
    // R6: reset state
    chk("R6", "loading in reset", loading, 1'b1);
    chk("R6", "sda released in reset", sda_oe, 1'b0);
    rst_n = 1'b1;
    // R6: address offered during the copy is not acknowledged
    i2c_start(); wbyte(VOL_W, a); i2c_stop();
    chk("R6", "nack while loading", a, 1'b1);
    chk("R6", "still loading after one byte", loading, 1'b1);
    while (loading) @(negedge clk);
    chk("R6", "loading cleared", loading, 1'b0);

    // R1 R4: fill the whole non-volatile bank, pattern 3 + 7*i via seed trick
    i2c_start();
    wbyte(NV_W, a); chk("R1", "nv address ack", a, 1'b0);
    wbyte(8'h00, a); chk("R4", "pointer ack", a, 1'b0);
    nk = 0;
    for (int i = 0; i < 256; i++) begin
      wbyte(8'(i * 7 + 3), a); if (a) nk++;
      nv_m[i] = 8'(i * 7 + 3);
    end
    i2c_stop();
    chk("R4", "nv fill nacks", nk, 0);

    // R6 R9: reset, working bank must equal the stored bank
    do_reset();
    for (int i = 0; i < 256; i++) begin
      raddr = 8'(i); @(negedge clk);
      chk("R9", "lookup after copy", rdata, nv_m[i]);
    end
    chk("R8", "pin default write-protect", pin_is_clk, 1'b0);

    // R2 R4: working bank write across the wrap 0xF8..0x07
    bus_write(VOL_W, 8'hF8, 16, 8'hA5, "R2", nk);
    chk("R2", "vol write nacks", nk, 0);
    for (int i = 0; i < 16; i++) vol_m[8'(8'hF8 + i)] = 8'(8'hA5 + i * 13);
    for (int i = 0; i < 256; i++) begin
      raddr = 8'(i); @(negedge clk);
      chk("R4", "wrap write via lookup", rdata, vol_m[i]);
    end
    // R5: repeated-start read across the wrap
    bus_read_check(VOL_W, 8'hF8, 16, 1'b0, "R5");
    // R1 R5: non-volatile read, then current-address read continues
    bus_read_check(NV_W, 8'h10, 32, 1'b1, "R1");
    i2c_start(); wbyte(NV_R, a); rbyte(1'b0, b); i2c_stop();
    chk("R5", "current address read", b, nv_m[8'h30]);

    // R7: protected non-volatile write NACKed, working bank still writable
    wp = 1'b1;
    bus_write(NV_W, 8'h40, 1, 8'h5A, "R7", nk);
    chk("R7", "protected data nack", nk, 1);
    bus_read_check(NV_W, 8'h40, 1, 1'b1, "R7");
    bus_write(VOL_W, 8'h40, 1, 8'h3C, "R7", nk);
    chk("R7", "vol writable under wp", nk, 0);
    vol_m[8'h40] = 8'h3C;
    raddr = 8'h40; @(negedge clk);
    chk("R7", "vol value under wp", rdata, 8'h3C);

    // R8: mode field set makes wp ignored
    bus_write(VOL_W, 8'h1F, 1, 8'h01, "R8", nk);
    vol_m[8'h1F] = 8'h01;
    chk("R8", "pin clock mode", pin_is_clk, 1'b1);
    bus_write(NV_W, 8'h40, 1, 8'h5A, "R8", nk);
    chk("R8", "nv write accepted with wp ignored", nk, 0);
    nv_m[8'h40] = 8'h5A;
    bus_read_check(NV_W, 8'h40, 1, 1'b1, "R8");
    bus_write(VOL_W, 8'h1F, 1, 8'h00, "R8", nk);
    vol_m[8'h1F] = 8'h00;
    chk("R8", "pin back to write-protect", pin_is_clk, 1'b0);
    bus_write(NV_W, 8'h41, 1, 8'h77, "R8", nk);
    chk("R8", "wp effective again", nk, 1);
    bus_read_check(NV_W, 8'h41, 1, 1'b1, "R8");

    // R3: foreign addresses
    wp = 1'b0;
    i2c_start();
    wbyte(8'hD4, a); chk("R3", "foreign address nack", a, 1'b1);
    wbyte(8'h40, a); chk("R3", "pointer after foreign nack", a, 1'b1);
    wbyte(8'h99, a); chk("R3", "data after foreign nack", a, 1'b1);
    i2c_stop();
    i2c_start(); wbyte(8'hD7, a); rbyte(1'b1, b); i2c_stop();
    chk("R3", "foreign read nack", a, 1'b1);
    chk("R3", "foreign read line idle", b, 8'hFF);
    raddr = 8'h40; @(negedge clk);
    chk("R3", "working reg untouched", rdata, vol_m[8'h40]);
    bus_read_check(NV_W, 8'h40, 1, 1'b1, "R3");
    nk = 0;
    for (int ad = 0; ad < 128; ad++) begin
      if (ad != 8'h68 && ad != 8'h69) begin
        i2c_start(); wbyte(8'(ad << 1), a); i2c_stop();
        if (!a) nk++;
      end
    end
    chk("R3", "address sweep acks", nk, 0);

    // R6: stored bank survives a second reset
    do_reset();
    for (int i = 0; i < 256; i++) begin
      raddr = 8'(i); @(negedge clk);
      chk("R6", "retained after reset", rdata, nv_m[i]);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule